// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers start-stop characters from a single serial input line. The line rests at logic 1. A character opens with a low start bit. Data bits follow least-significant first, then an optional parity bit, then a stop bit at logic 1. All timing comes from a one-cycle sample-enable pulse that the surrounding logic supplies at sixteen times the bit rate. The block does not generate that pulse.

The receiver confirms a start bit only when the line stays low across half a bit period of consecutive ticks. Shorter dips are treated as noise. Each later bit is then sampled one full bit period after the previous sample, which lands near the centre of the bit. Character length (5 to 8 bits) and parity mode (none, even, odd) are runtime inputs, and they are captured only while the receiver is idle. The recovered byte is presented in parallel, right-aligned, with a data-available flag. The same update carries a parity-error flag, a framing-error flag and an overrun flag. A one-cycle read strobe acknowledges the byte.

Top module: `async_serial_rx`

## Requirements
- R1: While the line stays at logic 1, no character is reported. After reset, `rx_valid`, `rx_data`, `parity_err`, `frame_err` and `overrun` are all zero.
- R2: Data bits are taken least-significant first. Their count is `cfg_len` + 5: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8.
- R3: The receiver advances only on cycles where `sample_tick` is high. With no ticks, a low line starts no character. Each bit lasts 16 ticks.
- R4: A start bit is accepted only when the line is low on 8 consecutive ticks. If the line returns high earlier, nothing is reported and the receiver returns to idle. A 7-tick low pulse is discarded.
- R5: `cfg_parity` 1 selects even parity and 2 selects odd parity. In these modes one parity bit follows the data. Even parity expects an even count of ones across data plus parity, and odd parity expects an odd count. A mismatch sets `parity_err` with that character. Codes 0 and 3 mean no parity bit, and `parity_err` stays 0.
- R6: A stop bit sampled at logic 0 sets `frame_err`, and the received data is still delivered. A stop bit at logic 1 gives `frame_err` 0.
- R7: If a character completes while `rx_valid` is still set and no read strobe comes in that cycle, `overrun` is set and the new data replaces the old. `rd_strobe` clears `overrun`.
- R8: `rx_valid` rises when the stop bit is sampled. It stays set until a one-cycle `rd_strobe` clears it. The data and error flags stay unchanged until the next character completes.
- R9: For characters shorter than 8 bits, the data is right-aligned in `rx_data` and the unused upper bits are zero.
- R10: `cfg_len` and `cfg_parity` are captured only while the receiver is idle. A change during a character does not affect that character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle enable at 16x bit rate |
| rx_line | input | 1 | Serial input, idle high, synchronous to clk |
| cfg_len | input | 2 | Data bit count minus 5 |
| cfg_parity | input | 2 | 0/3 none, 1 even, 2 odd |
| rd_strobe | input | 1 | One-cycle acknowledge of the received byte |
| rx_data | output | 8 | Received data, right-aligned |
| rx_valid | output | 1 | New data available |
| parity_err | output | 1 | Parity mismatch on the last character |
| frame_err | output | 1 | Stop bit was low on the last character |
| overrun | output | 1 | A character was lost before being read |

## Verification
The assertions check the following on every cycle:
- A cycle without a tick never moves the state machine.
- A high line during start validation always returns the machine to idle.
- The captured format stays stable for the whole character.
- A completed character never carries set bits above its length.
- A read strobe clears the flag unless a new character lands in the same cycle.
- An overrun only appears while unread data is present.

Only the bench scenarios can show the rest:
- The bit-level results for each length and parity mode.
- The exact 7-versus-8 tick boundary of the start filter.
- Data still being delivered when the stop bit is low.
- The format change during a character being ignored.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int MAX_BITS = 8;
  localparam int MIN_BITS = 5;
  localparam int IDX_W    = $clog2(MAX_BITS);
  localparam int NB_W     = IDX_W + 1;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF2 = 2'd3
  } parity_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_tick_counter.sv
module rx_tick_counter #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic half_hit,
  output logic full_hit
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign half_hit = (cnt_q == CW'(HALF - 1));
  assign full_hit = (cnt_q == CW'(OSR - 1));
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                line_i,
  input  logic [1:0]          len_i,
  input  logic [1:0]          par_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                perr_o,
  output logic                ferr_o
);
  rx_state_e           st_q, st_d;
  logic [MAX_BITS-1:0] shreg_q, shreg_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                acc_q, acc_d;
  logic                perr_q, perr_d;
  logic [1:0]          len_q, len_d;
  parity_e             par_q, par_d;
  logic                clr, half_hit, full_hit;
  logic [NB_W-1:0]     nbits;
  logic                last_bit, par_on, sample;

  rx_tick_counter #(.OSR(OSR)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clr      (clr),
    .half_hit (half_hit),
    .full_hit (full_hit)
  );

  assign nbits    = {{(NB_W-2){1'b0}}, len_q} + NB_W'(MIN_BITS);
  assign last_bit = ({1'b0, idx_q} == (nbits - NB_W'(1)));
  assign par_on   = (par_q == PAR_EVEN) || (par_q == PAR_ODD);
  assign sample   = tick && full_hit;

  always_comb begin
    st_d    = st_q;
    shreg_d = shreg_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    perr_d  = perr_q;
    len_d   = len_q;
    par_d   = par_q;
    clr     = 1'b0;
    done_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        len_d   = len_i;
        par_d   = parity_e'(par_i);
        shreg_d = '0;
        idx_d   = '0;
        acc_d   = 1'b0;
        perr_d  = 1'b0;
        clr     = !(tick && !line_i);
        if (tick && !line_i) st_d = ST_START;
      end
      ST_START: begin
        if (tick && line_i) begin
          clr  = 1'b1;
          st_d = ST_IDLE;
        end else if (tick && half_hit) begin
          clr  = 1'b1;
          st_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (sample) begin
          clr            = 1'b1;
          shreg_d[idx_q] = line_i;
          acc_d          = acc_q ^ line_i;
          idx_d          = idx_q + IDX_W'(1);
          if (last_bit) st_d = par_on ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: begin
        if (sample) begin
          clr    = 1'b1;
          perr_d = ((acc_q ^ line_i) != (par_q == PAR_ODD));
          st_d   = ST_STOP;
        end
      end
      ST_STOP: begin
        if (sample) begin
          clr    = 1'b1;
          done_o = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      len_q   <= '0;
      par_q   <= PAR_OFF;
    end else begin
      st_q    <= st_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      acc_q   <= acc_d;
      perr_q  <= perr_d;
      len_q   <= len_d;
      par_q   <= par_d;
    end
  end

  assign data_o = shreg_q;
  assign perr_o = perr_q;
  assign ferr_o = !line_i;

  // R3: no tick, no state movement
  assert_tick_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(st_q));
  // R4: a high level during start validation aborts the character
  assert_glitch_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && tick && line_i) |=> (st_q == ST_IDLE));
  // R10: captured format is frozen while a character is in flight
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> (st_q == ST_IDLE) || ($stable(len_q) && $stable(par_q)));
  // R9: nothing above the character length at completion
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((shreg_q >> nbits) == '0));
endmodule

// File: rtl/rx_result_reg.sv
module rx_result_reg
  import rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic                perr_i,
  input  logic                ferr_i,
  input  logic                rd_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                perr_o,
  output logic                ferr_o,
  output logic                ovr_o
);
  logic valid_d, ovr_d;

  always_comb begin
    valid_d = valid_o;
    ovr_d   = ovr_o;
    if (rd_i) begin
      valid_d = 1'b0;
      ovr_d   = 1'b0;
    end
    if (done_i) begin
      valid_d = 1'b1;
      ovr_d   = (valid_o && !rd_i) || (ovr_o && !rd_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      valid_o <= valid_d;
      ovr_o   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else if (done_i) begin
      data_o <= data_i;
      perr_o <= perr_i;
      ferr_o <= ferr_i;
    end
  end

  // R8: a read without a simultaneous completion drops the flag
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done_i) |=> !valid_o);
  // R7: overrun only appears over unread data
  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> $past(valid_o));
endmodule

// File: rtl/async_serial_rx.sv
module async_serial_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rx_line,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_parity,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       parity_err,
  output logic       frame_err,
  output logic       overrun
);
  logic       done;
  logic [7:0] fr_data;
  logic       fr_perr, fr_ferr;

  rx_frame_ctrl #(.OSR(OSR)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (sample_tick),
    .line_i (rx_line),
    .len_i  (cfg_len),
    .par_i  (cfg_parity),
    .done_o (done),
    .data_o (fr_data),
    .perr_o (fr_perr),
    .ferr_o (fr_ferr)
  );

  rx_result_reg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (done),
    .data_i  (fr_data),
    .perr_i  (fr_perr),
    .ferr_i  (fr_ferr),
    .rd_i    (rd_strobe),
    .data_o  (rx_data),
    .valid_o (rx_valid),
    .perr_o  (parity_err),
    .ferr_o  (frame_err),
    .ovr_o   (overrun)
  );
endmodule

// File: tb/sim_async_serial_rx.sv
module sim_async_serial_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_parity = 2'd0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, parity_err, frame_err, overrun;
  logic       tick_en = 1'b1;
  logic [1:0] div_q = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) div_q <= div_q + 2'd1;
  assign sample_tick = tick_en && (div_q == 2'd3);

  async_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
    .frame_err(frame_err), .overrun(overrun)
  );

  // {len, parity, data, bad_parity, bad_stop, exp_data, exp_perr, exp_ferr}
  localparam logic [23:0] VEC [9] = '{
    {2'd3, 2'd0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {2'd0, 2'd0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    {2'd1, 2'd1, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {2'd2, 2'd2, 8'h7F, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b0},
    {2'd3, 2'd2, 8'h81, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0},
    {2'd3, 2'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
    {2'd0, 2'd2, 8'h15, 1'b1, 1'b0, 8'h15, 1'b1, 1'b0},
    {2'd3, 2'd3, 8'h5A, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0},
    {2'd2, 2'd1, 8'hC3, 1'b0, 1'b0, 8'h43, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!sample_tick);
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      @(posedge clk);
    end
  endtask

  task automatic send(input logic [1:0] len, input logic [1:0] par, input logic [7:0] d,
                      input bit badpar, input bit badstop, input bit swap_cfg);
    int nb;
    logic [7:0] msk;
    logic p;
    nb  = int'(len) + 5;
    msk = 8'hFF >> (8 - nb);
    cfg_len = len;
    cfg_parity = par;
    hold(1'b0, 16);
    if (swap_cfg) begin
      cfg_len = ~len;
      cfg_parity = 2'd1;
    end
    for (int i = 0; i < nb; i++) hold(d[i], 16);
    if (par == 2'd1 || par == 2'd2) begin
      p = ^(d & msk);
      if (par == 2'd2) p = ~p;
      if (badpar) p = ~p;
      hold(p, 16);
    end
    if (badstop) hold(1'b0, 9);
    hold(1'b1, 24);
    @(negedge clk);
  endtask

  task automatic read_out();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold(1'b1, 40);
    @(negedge clk);
    // R1: reset state and idle line
    chk("R1 valid", rx_valid, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 perr", parity_err, 0);
    chk("R1 ferr", frame_err, 0);
    chk("R1 ovr", overrun, 0);

    // R2 R5 R6 R8 R9: table of formats
    foreach (VEC[k]) begin
      send(VEC[k][23:22], VEC[k][21:20], VEC[k][19:12], VEC[k][11], VEC[k][10], 1'b0);
      chk("R8 valid set", rx_valid, 1);
      chk("R2 R9 data", rx_data, VEC[k][9:2]);
      chk("R5 parity_err", parity_err, VEC[k][1]);
      chk("R6 frame_err", frame_err, VEC[k][0]);
      chk("R7 no overrun", overrun, 0);
      read_out();
      chk("R8 valid cleared", rx_valid, 0);
      chk("R8 data held", rx_data, VEC[k][9:2]);
    end

    // R4: 7-tick low pulse is discarded, 8-tick boundary accepted via normal frames
    hold(1'b0, 7);
    hold(1'b1, 40);
    @(negedge clk);
    chk("R4 glitch ignored", rx_valid, 0);
    send(2'd3, 2'd0, 8'h6B, 1'b0, 1'b0, 1'b0);
    chk("R4 recovery data", rx_data, 8'h6B);
    chk("R4 recovery valid", rx_valid, 1);
    read_out();

    // R3: low line without ticks starts nothing
    tick_en = 1'b0;
    rx_line = 1'b0;
    repeat (300) @(negedge clk);
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b1;
    hold(1'b1, 40);
    @(negedge clk);
    chk("R3 no tick no start", rx_valid, 0);
    send(2'd3, 2'd0, 8'h2E, 1'b0, 1'b0, 1'b0);
    chk("R3 data after pause", rx_data, 8'h2E);
    read_out();

    // R10: format changed mid-character is ignored
    send(2'd3, 2'd0, 8'hE7, 1'b0, 1'b0, 1'b1);
    chk("R10 data", rx_data, 8'hE7);
    chk("R10 perr", parity_err, 0);
    chk("R10 valid", rx_valid, 1);
    read_out();

    // R7: overrun when unread
    send(2'd3, 2'd0, 8'h11, 1'b0, 1'b0, 1'b0);
    send(2'd3, 2'd0, 8'h22, 1'b0, 1'b0, 1'b0);
    chk("R7 overrun set", overrun, 1);
    chk("R7 newest data", rx_data, 8'h22);
    read_out();
    chk("R7 overrun cleared", overrun, 0);
    chk("R8 valid cleared after overrun", rx_valid, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule